// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Unit

This block is the processor-facing half of an interrupt controller. The distributor side feeds it a vector of interrupts that are pending, enabled and routed to this processor, together with a priority for each one and a source processor number for each software-generated interrupt. From the candidates that are not already being serviced, the unit picks the most urgent one. It then decides whether that interrupt may interrupt the processor, given a priority mask, the priority of the work already in progress and a preemption grouping setting.

Software uses a small 32-bit register bus. A read of the acknowledge register claims the chosen interrupt. The interrupt is marked active, the running priority rises to it, and a one-cycle claim pulse with its ID goes back to the distributor so that the pending state there can be cleared. When nothing may be taken, the read returns a reserved spurious ID. A write of an ID to the end-of-interrupt register retires that interrupt. The running priority then falls back to the most urgent interrupt that is still active, or to idle. A separate register shows the best candidate without claiming it.

Top module: `cpuif_ack_unit`

## Requirements
- R1: After reset the enable bit, priority mask and binary point are 0, no interrupt is active, `irq_o` and `ack_o` are 0, and the running priority reads as idle (all ones in PRIO_W bits).
- R2: The candidate is the interrupt with the lowest numeric priority among those pending and not active. Equal priorities go to the lowest ID.
- R3: `irq_o` is registered, so it follows its conditions one cycle later. It is 1 only when the enable bit (offset 0x00, bit 0) is set, the candidate priority is strictly below the mask (offset 0x04), and either no interrupt is active or the preemption test of R9 passes.
- R4: A read at offset 0x0C while `irq_o` would be asserted does four things. It returns the candidate ID in bits 9:0 and, for IDs below NUM_SGI, the source processor in bits 12:10. It makes the interrupt active. It pulses `ack_o` for one cycle with `ack_id_o` set to that ID.
- R5: When no interrupt qualifies under R3, a read at 0x0C returns 1023, marks nothing active and does not pulse `ack_o`.
- R6: A read at offset 0x14 returns the lowest priority value among the active interrupts. With none active it returns all ones.
- R7: A write of an ID to offset 0x10 clears that interrupt's active bit. IDs of NUM_IRQ or above, including the reserved values 1020 to 1023, have no effect.
- R8: A read at offset 0x18 returns the R2 candidate (ID and source, as in R4), or 1023 when there is none. It has no side effect.
- R9: With binary point b (offset 0x08, bits 2:0), the b lowest priority bits are dropped in the preemption comparison. An active interrupt is preempted only if the candidate's remaining upper bits are strictly lower than those of the running priority.
- R10: Register reads complete one cycle after the request, with `rvalid_o` high for one cycle. The mask reads back in bits PRIO_W-1:0 and the binary point in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_IRQ | Pending, enabled and routed interrupts |
| prio_i | input | NUM_IRQ*PRIO_W | Priority per interrupt; ID k at bits k*PRIO_W |
| sgi_src_i | input | NUM_SGI*3 | Source processor per software interrupt |
| req_i | input | 1 | Bus request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_o | output | 1 | Claim pulse to the distributor |
| ack_id_o | output | 10 | Claimed ID |

## Verification
The bench builds the unit with NUM_IRQ = 20, NUM_SGI = 4 and PRIO_W = 5. With 20 interrupts, an end-of-interrupt write of a legal but unimplemented ID is easy to issue. With 4 software interrupts, one source-number return and one ordinary return are both in reach. The 5-bit priorities make the idle value 31 and keep the mask and binary point boundaries, such as equal groups and a mask equal to the priority, at a handful of values. A model of the distributor clears pending bits on each claim pulse, so nesting, out-of-order retirement and spurious reads all happen on one pending set.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int ID_W  = 10;
  localparam int SRC_W = 3;
  localparam logic [ID_W-1:0] ID_SPURIOUS = 10'd1023;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MASK = 8'h04;
  localparam logic [7:0] OFS_BPT  = 8'h08;
  localparam logic [7:0] OFS_ACK  = 8'h0C;
  localparam logic [7:0] OFS_EOI  = 8'h10;
  localparam logic [7:0] OFS_RUN  = 8'h14;
  localparam logic [7:0] OFS_HPEN = 8'h18;
endpackage

// File: rtl/cpuif_arbiter.sv
module cpuif_arbiter #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0]        cand_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  output logic                      found_o,
  output logic [IDX_W-1:0]          win_idx_o,
  output logic [PRIO_W-1:0]         win_prio_o
);
  // Linear scan with a strict compare: the first (lowest) ID wins ties.
  always_comb begin
    found_o    = 1'b0;
    win_idx_o  = '0;
    win_prio_o = '1;
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (cand_i[k] && (!found_o || prio_i[k*PRIO_W +: PRIO_W] < win_prio_o)) begin
        found_o    = 1'b1;
        win_idx_o  = IDX_W'(k);
        win_prio_o = prio_i[k*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/cpuif_active.sv
module cpuif_active #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      set_v_i,
  input  logic [IDX_W-1:0]          set_idx_i,
  input  logic                      clr_v_i,
  input  logic [IDX_W-1:0]          clr_idx_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  output logic [NUM_IRQ-1:0]        active_o,
  output logic                      any_o,
  output logic [PRIO_W-1:0]         run_prio_o
);
  logic [NUM_IRQ-1:0] act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
    end else begin
      if (clr_v_i) act_q[clr_idx_i] <= 1'b0;
      if (set_v_i) act_q[set_idx_i] <= 1'b1;
    end
  end

  // Running priority: most urgent active interrupt, idle = all ones.
  always_comb begin
    run_prio_o = '1;
    for (int k = 0; k < NUM_IRQ; k++)
      if (act_q[k] && prio_i[k*PRIO_W +: PRIO_W] < run_prio_o)
        run_prio_o = prio_i[k*PRIO_W +: PRIO_W];
  end

  assign active_o = act_q;
  assign any_o    = |act_q;

  a_r4_set_marks_active: assert property (@(posedge clk) disable iff (rst)
    set_v_i |=> act_q[$past(set_idx_i)]);
  a_r7_eoi_clears_active: assert property (@(posedge clk) disable iff (rst)
    (clr_v_i && !set_v_i) |=> !act_q[$past(clr_idx_i)]);
  a_r6_idle_when_none: assert property (@(posedge clk) disable iff (rst)
    !any_o |-> (run_prio_o == '1));
endmodule

// File: rtl/cpuif_ack_unit.sv
module cpuif_ack_unit
  import cpuif_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int NUM_SGI = 16,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IRQ-1:0]        pend_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  input  logic [NUM_SGI*SRC_W-1:0]  sgi_src_i,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [7:0]                addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic                      rvalid_o,
  output logic                      irq_o,
  output logic                      ack_o,
  output logic [ID_W-1:0]           ack_id_o
);
  logic              en_q;
  logic [PRIO_W-1:0] mask_q;
  logic [2:0]        bpt_q;

  logic [NUM_IRQ-1:0] active, cand;
  logic               any_act, found, qualify, take, clr_v;
  logic [IDX_W-1:0]   win_idx;
  logic [PRIO_W-1:0]  win_prio, run_prio, gmask;
  logic [SRC_W-1:0]   win_src;
  logic [31:0]        cand_word, rd_mux;

  assign cand = pend_i & ~active;

  cpuif_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .cand_i(cand), .prio_i(prio_i),
    .found_o(found), .win_idx_o(win_idx), .win_prio_o(win_prio));

  assign take  = req_i && !we_i && (addr_i == OFS_ACK) && en_q && qualify;
  assign clr_v = req_i && we_i && (addr_i == OFS_EOI) &&
                 (wdata_i[ID_W-1:0] < ID_W'(NUM_IRQ));

  cpuif_active #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_act (
    .clk(clk), .rst(rst),
    .set_v_i(take), .set_idx_i(win_idx),
    .clr_v_i(clr_v), .clr_idx_i(wdata_i[IDX_W-1:0]),
    .prio_i(prio_i), .active_o(active), .any_o(any_act), .run_prio_o(run_prio));

  // Preemption group: drop the bpt_q lowest priority bits.
  assign gmask   = {PRIO_W{1'b1}} << bpt_q;
  assign qualify = found && (win_prio < mask_q) &&
                   (!any_act || ((win_prio & gmask) < (run_prio & gmask)));

  always_comb begin
    win_src = '0;
    for (int k = 0; k < NUM_SGI; k++)
      if (int'(win_idx) == k) win_src = sgi_src_i[k*SRC_W +: SRC_W];
    cand_word = {19'd0, win_src, ID_W'(win_idx)};
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFS_CTRL: rd_mux = {31'd0, en_q};
      OFS_MASK: rd_mux = 32'(mask_q);
      OFS_BPT:  rd_mux = {29'd0, bpt_q};
      OFS_ACK:  rd_mux = take ? cand_word : 32'(ID_SPURIOUS);
      OFS_RUN:  rd_mux = 32'(run_prio);
      OFS_HPEN: rd_mux = found ? cand_word : 32'(ID_SPURIOUS);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      mask_q   <= '0;
      bpt_q    <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      irq_o    <= 1'b0;
      ack_o    <= 1'b0;
      ack_id_o <= '0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_mux;
      if (req_i && we_i) begin
        if (addr_i == OFS_CTRL) en_q   <= wdata_i[0];
        if (addr_i == OFS_MASK) mask_q <= wdata_i[PRIO_W-1:0];
        if (addr_i == OFS_BPT)  bpt_q  <= wdata_i[2:0];
      end
      irq_o    <= en_q && qualify;
      ack_o    <= take;
      ack_id_o <= ID_W'(win_idx);
    end
  end

  a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(en_q));
  a_r4_claim_is_active: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> active[ack_id_o[IDX_W-1:0]]);
  a_r4_claim_in_range: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (ack_id_o < ID_W'(NUM_IRQ)));
  a_r2_winner_is_candidate: assert property (@(posedge clk) disable iff (rst)
    found |-> (pend_i[win_idx] && !active[win_idx]));
  a_r5_spurious_no_claim: assert property (@(posedge clk) disable iff (rst)
    (rvalid_o && rdata_o[ID_W-1:0] == ID_SPURIOUS) |-> !ack_o);
endmodule

// File: tb/cpuif_ack_unit_bench.sv
module cpuif_ack_unit_bench;
  localparam int N  = 20;
  localparam int NS = 4;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    pend = '0;
  logic [N*PW-1:0] prio = '0;
  logic [NS*3-1:0] src  = '0;
  logic req = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid, irq, ack;
  logic [9:0] ack_id;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  cpuif_ack_unit #(.NUM_IRQ(N), .NUM_SGI(NS), .PRIO_W(PW)) u_cpuif_ack_unit (
    .clk(clk), .rst(rst), .pend_i(pend), .prio_i(prio), .sgi_src_i(src),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq), .ack_o(ack), .ack_id_o(ack_id));

  // Distributor model: a claim clears the pending bit.
  always @(posedge clk) if (ack && ack_id < N) pend[ack_id] <= 1'b0;

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rvalid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++; $display("FAIL R10: unexpected read data %0d", rdata);
      end else begin
        logic [31:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (rdata !== e) begin
          n_bad++; $display("FAIL %s: read got %0d expected %0d", t, rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic chk(input logic got, input logic e, input string t);
    n_chk++;
    if (got !== e) begin
      n_bad++; $display("FAIL %s: got %0d expected %0d", t, got, e);
    end
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic setp(input int id, input int p);
    prio[id*PW +: PW] = PW'(p);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(irq, 0, "R1 irq");
        chk(ack, 0, "R1 ack");
        rd(8'h00, 0, "R1 ctrl");
        rd(8'h04, 0, "R1 mask");
        rd(8'h08, 0, "R1 bpt");
        rd(8'h14, 31, "R1 R6 idle run");
        rd(8'h18, 1023, "R8 none pending");
        chk(rvalid, 1, "R10 rvalid");
        @(negedge clk); chk(rvalid, 0, "R10 rvalid single");
        // pending set
        setp(5, 10); setp(9, 10); setp(2, 12); src[2*3 +: 3] = 3'd3;
        pend[5] = 1; pend[9] = 1; pend[2] = 1;
        settle();
        chk(irq, 0, "R3 mask zero");
        rd(8'h0C, 1023, "R5 masked spurious");
        chk(ack, 0, "R5 no claim");
        wr(8'h00, 1); wr(8'h04, 31);
        rd(8'h04, 31, "R10 mask read");
        settle();
        chk(irq, 1, "R3 irq up");
        rd(8'h18, 5, "R2 R8 tie lowest id");
        rd(8'h0C, 5, "R4 ack id");
        chk(ack, 1, "R4 ack pulse");
        chk(ack_id == 5, 1, "R4 ack id out");
        @(negedge clk); chk(ack, 0, "R4 pulse one cycle");
        rd(8'h14, 10, "R6 run after ack");
        settle();
        chk(irq, 0, "R3 equal prio no preempt");
        rd(8'h0C, 1023, "R5 not preempting");
        rd(8'h18, 9, "R8 candidate excludes active");
        rd(8'h18, 9, "R8 no side effect");
        // software interrupt with source
        setp(3, 4); src[3*3 +: 3] = 3'd6; pend[3] = 1;
        settle();
        chk(irq, 1, "R3 preempt");
        rd(8'h0C, (6 << 10) | 3, "R4 source bits");
        rd(8'h14, 4, "R6 nested run");
        wr(8'h10, 5);
        rd(8'h14, 4, "R7 R6 out of order eoi");
        wr(8'h10, 3);
        rd(8'h14, 31, "R7 R6 back to idle");
        rd(8'h0C, 9, "R4 ack next");
        wr(8'h10, 1022);
        wr(8'h10, 19);
        rd(8'h14, 10, "R7 reserved eoi ignored");
        wr(8'h10, 9);
        rd(8'h14, 31, "R7 idle again");
        // binary point
        wr(8'h08, 2);
        rd(8'h08, 2, "R10 bpt read");
        setp(7, 9); pend[7] = 1;
        settle();
        rd(8'h0C, 7, "R2 lower prio wins");
        setp(11, 8); pend[11] = 1;
        settle();
        chk(irq, 0, "R9 same group no preempt");
        wr(8'h08, 0);
        settle();
        chk(irq, 1, "R9 finer group preempts");
        wr(8'h04, 8);
        settle();
        chk(irq, 0, "R3 mask equal blocks");
        wr(8'h04, 9);
        settle();
        chk(irq, 1, "R3 mask above passes");
        wr(8'h00, 0);
        settle();
        chk(irq, 0, "R3 disabled");
        rd(8'h0C, 1023, "R5 disabled spurious");
        settle();
        chk(exp_q.size() == 0, 1, "R10 all reads returned");
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule